// File: doc/BRIEF.md
# Oscillator-Pair Counter Random Bit Harvester

This block produces random data from two counters that race against each other. Each counter is driven by an external ring oscillator. The oscillators themselves sit outside the block, and each one arrives as a free-running toggle line. The block runs each line through a two-flop synchroniser and counts every transition it sees. A run is a programmed number of competitions. Each competition clears both counters and then lets them count for a fixed window of system clocks. At the end of the window the low two bits of each counter are taken, in either plain binary or Gray form. These are joined into a 4-bit sample, and the sample is packed into words of an internal memory.

The host writes a control word that holds the competition count, the code select, the pair-distance select, a start bit and a clear bit. The pair-distance select decides which oscillator races against oscillator 0: the nearest neighbour or the farthest line. An XOR bias corrector halves the bit rate, and it is active for every code/distance combination except binary with the farthest pair. The host reads status outputs: a fixed identifier, the active configuration, the write address and a done flag. It fetches the harvested words through a read-address port.

Top module: `ro_pair_harvester`

## Requirements
- R1: After reset the done flag is 0 and the write address is 0. The identifier reads 8'h5A. The configuration reads count 4, binary coding (code select 0) and farthest pair (distance select 1).
- R2: A control write with the clear bit set returns count, code select and distance select to their reset values and does not start a run. A control write with start 0 and clear 0 only loads the three fields.
- R3: Counter A always counts oscillator line 0. Counter B counts line NUM_OSC-1 when the distance select is 1 and line 1 when it is 0. Transitions on the other lines have no effect on the stored data.
- R4: Each competition forms a 4-bit sample from the low two bits of counter A (bits 3:2) and of counter B (bits 1:0). In Gray mode (code select 1) the low two bits of a count c are {c[1]^c[2], c[0]^c[1]}. In binary mode they are c[1:0].
- R5: Both counters are cleared at the start of every competition and count only during its WINDOW-clock window. Counts never carry over from one competition to the next.
- R6: The count field sets the number of competitions. The done flag rises once the last one has been stored. A count of 0 raises done within two clocks of the start and writes nothing.
- R7: With binary coding and the farthest pair the corrector is bypassed. In every other combination a sample s becomes the two bits {s[3]^s[2], s[1]^s[0]}, and four of these fill one 8-bit word, with the first competition in bits 1:0.
- R8: When the corrector is bypassed, two raw samples fill one word, with the first in bits 3:0. Any partly filled word is stored at the end of a run, and its unused bits are 0.
- R9: A start resets the write address to 0. The address then advances by one for each stored word and wraps modulo MEM_DEPTH. The read port returns the word at the read address in the same cycle.
- R10: While a run is in progress, control writes (start, clear and fields) are ignored. The done flag holds until the next accepted start or until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| roToggle | input | NUM_OSC | Oscillator toggle lines, asynchronous |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlCount | input | COMP_W | Number of competitions |
| ctrlGray | input | 1 | 1 = Gray coding, 0 = binary |
| ctrlFar | input | 1 | 1 = farthest pair, 0 = closest pair |
| ctrlStart | input | 1 | Start a run with the written fields |
| ctrlClear | input | 1 | Restore the configuration defaults |
| rdAddr | input | ADDR_W | Output memory read address |
| rdData | output | 8 | Output memory word at rdAddr |
| statWrAddr | output | ADDR_W | Current write address |
| statDone | output | 1 | Run complete flag |
| statId | output | 8 | Fixed block identifier |
| statCount | output | COMP_W | Active competition count |
| statGray | output | 1 | Active code select |
| statFar | output | 1 | Active distance select |

## Verification
The bench drives exact toggle counts into each window. Counts are chosen so that Gray and binary low bits differ, and so that a counter that kept its value across competitions would give different samples. Noise toggles on the lines that are not selected would show up as wrong samples if the pair multiplexer were inverted. A run of three samples with the corrector bypassed checks that the half-filled word is flushed with zero padding rather than dropped. A run started with count 0 must finish at once with an empty memory. A restart written during a run must leave the fields and the competition count untouched: a design that accepted it would report the new fields and would not raise done at the original finishing time.

// File: rtl/harv_pkg.sv
package harv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUN,
    ST_CAPT,
    ST_FLUSH
  } harvState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic runStart;  // new run accepted: reset packer and write pointer
    logic clrCnt;    // clear both race counters
    logic cntEn;     // competition window open
    logic capture;   // take the sample of the finished competition
    logic flush;     // store any partly filled word, run is over
  } harvStrb_t;

  // Low two bits of a counter in the selected coding
  function automatic logic [1:0] lowCode(input logic [2:0] c, input logic gray);
    return gray ? {c[1] ^ c[2], c[0] ^ c[1]} : c[1:0];
  endfunction

endpackage

// File: rtl/harv_ctrl.sv
module harv_ctrl
  import harv_pkg::*;
#(
  parameter int          COMP_W    = 8,
  parameter int          WINDOW    = 256,
  parameter logic [COMP_W-1:0] DEF_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [COMP_W-1:0] ctrlCount,
  input  logic              ctrlGray,
  input  logic              ctrlFar,
  input  logic              ctrlStart,
  input  logic              ctrlClear,
  output logic [COMP_W-1:0] cfgCount,
  output logic              cfgGray,
  output logic              cfgFar,
  output logic              done,
  output harvStrb_t         strb
);

  localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  harvState_t        state, stateNext;
  logic [COMP_W-1:0] remaining;
  logic [WIN_W-1:0]  winCnt;
  logic              idle, writeOk, startOk;

  assign idle    = (state == ST_IDLE);
  assign writeOk = ctrlWe && idle;
  assign startOk = writeOk && !ctrlClear && ctrlStart;

  // configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCount <= DEF_COUNT;
      cfgGray  <= 1'b0;
      cfgFar   <= 1'b1;
    end else if (writeOk) begin
      if (ctrlClear) begin
        cfgCount <= DEF_COUNT;
        cfgGray  <= 1'b0;
        cfgFar   <= 1'b1;
      end else begin
        cfgCount <= ctrlCount;
        cfgGray  <= ctrlGray;
        cfgFar   <= ctrlFar;
      end
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startOk) stateNext = (ctrlCount == '0) ? ST_FLUSH : ST_CLEAR;
      ST_CLEAR: stateNext = ST_RUN;
      ST_RUN:   if (winCnt == WIN_LAST) stateNext = ST_CAPT;
      ST_CAPT:  stateNext = (remaining == COMP_W'(1)) ? ST_FLUSH : ST_CLEAR;
      ST_FLUSH: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      winCnt    <= '0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      if (startOk) begin
        remaining <= ctrlCount;
        done      <= 1'b0;
      end
      if (state == ST_CLEAR) winCnt <= '0;
      else if (state == ST_RUN) winCnt <= winCnt + 1'b1;
      if (state == ST_CAPT) remaining <= remaining - 1'b1;
      if (state == ST_FLUSH) done <= 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.runStart = startOk;
    strb.clrCnt   = (state == ST_CLEAR);
    strb.cntEn    = (state == ST_RUN);
    strb.capture  = (state == ST_CAPT);
    strb.flush    = (state == ST_FLUSH);
  end

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> idle); // R6
  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> !done); // R10
  AST_BUSY_CFG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> ($stable(cfgCount) && $stable(cfgGray) && $stable(cfgFar))); // R10
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrCnt, strb.cntEn, strb.capture, strb.flush})); // R5
  AST_LAST_CAPT_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPT && remaining == COMP_W'(1)) |=> strb.flush); // R6

endmodule

// File: rtl/harv_datapath.sv
module harv_datapath
  import harv_pkg::*;
#(
  parameter int NUM_OSC   = 4,
  parameter int CNT_W     = 3,
  parameter int MEM_DEPTH = 16,
  parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] roToggle,
  input  harvStrb_t          strb,
  input  logic               cfgGray,
  input  logic               cfgFar,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [7:0]         rdData,
  output logic [ADDR_W-1:0]  wrAddr
);

  localparam int WORD_W    = 8;
  localparam int SAMPLE_W  = 4;
  localparam int PAIR_W    = SAMPLE_W / 2;
  localparam int FAR_IDX   = NUM_OSC - 1;

  // synchronise every oscillator line and detect transitions
  logic [NUM_OSC-1:0] syncA, syncB, syncPrev, oscEdge;

  generate
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[g]    <= 1'b0;
          syncB[g]    <= 1'b0;
          syncPrev[g] <= 1'b0;
        end else begin
          syncA[g]    <= roToggle[g];
          syncB[g]    <= syncA[g];
          syncPrev[g] <= syncB[g];
        end
      end
      assign oscEdge[g] = syncB[g] ^ syncPrev[g];
    end
  endgenerate

  // pair routing: counter 0 always line 0, counter 1 near or far line
  logic [1:0] raceEdge;
  assign raceEdge[0] = oscEdge[0];
  assign raceEdge[1] = cfgFar ? oscEdge[FAR_IDX] : oscEdge[1];

  logic [CNT_W-1:0] raceCnt [2];

  generate
    for (genvar c = 0; c < 2; c++) begin : g_cnt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          raceCnt[c] <= '0;
        else if (strb.clrCnt)               raceCnt[c] <= '0;
        else if (strb.cntEn && raceEdge[c]) raceCnt[c] <= raceCnt[c] + 1'b1;
      end

      AST_COUNT_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
        (!strb.cntEn && !strb.clrCnt) |=> $stable(raceCnt[c])); // R5
      AST_CLEAR_EACH_COMP: assert property (@(posedge clk) disable iff (!rstN)
        strb.clrCnt |=> (raceCnt[c] == '0)); // R5
    end
  endgenerate

  // sample and optional corrector
  logic [SAMPLE_W-1:0] sample;
  logic [PAIR_W-1:0]   corrBits;
  logic                corrOn;

  assign sample   = {lowCode(raceCnt[0][2:0], cfgGray), lowCode(raceCnt[1][2:0], cfgGray)};
  assign corrBits = {sample[3] ^ sample[2], sample[1] ^ sample[0]};
  assign corrOn   = cfgGray || !cfgFar;

  // packer
  logic [1:0]        slot;
  logic [WORD_W-1:0] packBuf, nextBuf, memWord;
  logic              wordFull, memWe;

  always_comb begin
    nextBuf = packBuf;
    if (corrOn) nextBuf[slot*PAIR_W +: PAIR_W]     = corrBits;
    else        nextBuf[slot[0]*SAMPLE_W +: SAMPLE_W] = sample;
  end

  assign wordFull = corrOn ? (slot == 2'd3) : (slot == 2'd1);
  assign memWe    = (strb.capture && wordFull) || (strb.flush && slot != 2'd0);
  assign memWord  = strb.capture ? nextBuf : packBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot    <= '0;
      packBuf <= '0;
      wrAddr  <= '0;
    end else if (strb.runStart) begin
      slot    <= '0;
      packBuf <= '0;
      wrAddr  <= '0;
    end else begin
      if (strb.capture) begin
        if (wordFull) begin
          slot    <= '0;
          packBuf <= '0;
        end else begin
          slot    <= slot + 1'b1;
          packBuf <= nextBuf;
        end
      end else if (strb.flush) begin
        slot    <= '0;
        packBuf <= '0;
      end
      if (memWe) wrAddr <= wrAddr + 1'b1;
    end
  end

  logic [WORD_W-1:0] outMem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (memWe) outMem[wrAddr] <= memWord;
  end

  assign rdData = outMem[rdAddr];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !strb.runStart) |=> (wrAddr == $past(wrAddr) + 1'b1)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!memWe && !strb.runStart) |=> $stable(wrAddr)); // R9
  AST_RAW_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !corrOn) |-> (slot <= 2'd1)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (slot == 2'd0)); // R8

endmodule

// File: rtl/ro_pair_harvester.sv
module ro_pair_harvester
  import harv_pkg::*;
#(
  parameter int              NUM_OSC   = 4,
  parameter int              CNT_W     = 3,
  parameter int              WINDOW    = 256,
  parameter int              COMP_W    = 8,
  parameter int              MEM_DEPTH = 16,
  parameter int              ADDR_W    = $clog2(MEM_DEPTH),
  parameter logic [7:0]      HARV_ID   = 8'h5A,
  parameter logic [COMP_W-1:0] DEF_COUNT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] roToggle,
  input  logic               ctrlWe,
  input  logic [COMP_W-1:0]  ctrlCount,
  input  logic               ctrlGray,
  input  logic               ctrlFar,
  input  logic               ctrlStart,
  input  logic               ctrlClear,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [7:0]         rdData,
  output logic [ADDR_W-1:0]  statWrAddr,
  output logic               statDone,
  output logic [7:0]         statId,
  output logic [COMP_W-1:0]  statCount,
  output logic               statGray,
  output logic               statFar
);

  harvStrb_t strb;

  assign statId = HARV_ID;

  harv_ctrl #(
    .COMP_W   (COMP_W),
    .WINDOW   (WINDOW),
    .DEF_COUNT(DEF_COUNT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlCount(ctrlCount),
    .ctrlGray (ctrlGray),
    .ctrlFar  (ctrlFar),
    .ctrlStart(ctrlStart),
    .ctrlClear(ctrlClear),
    .cfgCount (statCount),
    .cfgGray  (statGray),
    .cfgFar   (statFar),
    .done     (statDone),
    .strb     (strb)
  );

  harv_datapath #(
    .NUM_OSC  (NUM_OSC),
    .CNT_W    (CNT_W),
    .MEM_DEPTH(MEM_DEPTH),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .roToggle(roToggle),
    .strb    (strb),
    .cfgGray (statGray),
    .cfgFar  (statFar),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .wrAddr  (statWrAddr)
  );

endmodule

// File: tb/tb_ro_pair_harvester.sv
`timescale 1ns/1ps
module tb_ro_pair_harvester;

  localparam int NUM_OSC = 4;
  localparam int COMP_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int PERIOD  = 258;  // clear + window + capture

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_OSC-1:0] osc = '0;
  logic               ctrlWe = 1'b0;
  logic [COMP_W-1:0]  ctrlCount = '0;
  logic               ctrlGray = 1'b0, ctrlFar = 1'b0, ctrlStart = 1'b0, ctrlClear = 1'b0;
  logic [ADDR_W-1:0]  rdAddr = '0;
  logic [7:0]         rdData;
  logic [ADDR_W-1:0]  statWrAddr;
  logic               statDone;
  logic [7:0]         statId;
  logic [COMP_W-1:0]  statCount;
  logic               statGray, statFar;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ro_pair_harvester dut (
    .clk(clk), .rstN(rstN), .roToggle(osc),
    .ctrlWe(ctrlWe), .ctrlCount(ctrlCount), .ctrlGray(ctrlGray), .ctrlFar(ctrlFar),
    .ctrlStart(ctrlStart), .ctrlClear(ctrlClear),
    .rdAddr(rdAddr), .rdData(rdData), .statWrAddr(statWrAddr), .statDone(statDone),
    .statId(statId), .statCount(statCount), .statGray(statGray), .statFar(statFar)
  );

  // {gray, far, a0,b0, a1,b1, a2,b2, a3,b3}, 6 bits per count
  localparam logic [49:0] VEC [4] = '{
    {1'b0, 1'b1, 6'd5, 6'd3, 6'd6, 6'd9, 6'd1, 6'd2, 6'd7, 6'd0},
    {1'b1, 1'b0, 6'd2, 6'd7, 6'd4, 6'd5, 6'd3, 6'd3, 6'd12, 6'd1},
    {1'b0, 1'b0, 6'd1, 6'd6, 6'd10, 6'd2, 6'd7, 6'd7, 6'd0, 6'd4},
    {1'b1, 1'b1, 6'd9, 6'd14, 6'd6, 6'd3, 6'd15, 6'd0, 6'd2, 6'd11}
  };

  function automatic logic [1:0] lowBits(input int c, input bit gray);
    logic [2:0] b;
    b = c[2:0];
    return gray ? {b[1] ^ b[2], b[0] ^ b[1]} : b[1:0];
  endfunction

  function automatic logic [3:0] sampleOf(input int a, input int b, input bit gray);
    return {lowBits(a, gray), lowBits(b, gray)};
  endfunction

  function automatic logic [1:0] xorPair(input logic [3:0] s);
    return {s[3] ^ s[2], s[1] ^ s[0]};
  endfunction

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic writeCtrl(input int cnt, input bit gray, input bit far,
                           input bit start, input bit clear);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlCount = COMP_W'(cnt); ctrlGray = gray; ctrlFar = far;
    ctrlStart = start; ctrlClear = clear;
    @(negedge clk);
    ctrlWe = 1'b0; ctrlStart = 1'b0; ctrlClear = 1'b0;
  endtask

  // one competition period, aligned to the negedge after the start edge
  task automatic runComp(input int a, input int b, input bit far);
    int noise;
    noise = (a + b) % 5 + 2;
    repeat (30) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (i < a) osc[0] = ~osc[0];
      if (i < b) osc[far ? NUM_OSC-1 : 1] = ~osc[far ? NUM_OSC-1 : 1];
      if (i < noise) begin
        osc[2] = ~osc[2];
        osc[far ? 1 : NUM_OSC-1] = ~osc[far ? 1 : NUM_OSC-1];
      end
      repeat (4) @(negedge clk);
    end
    repeat (PERIOD - 30 - 160) @(negedge clk);
  endtask

  task automatic waitDone(input int maxCyc);
    for (int i = 0; i < maxCyc && !statDone; i++) @(negedge clk);
  endtask

  task automatic readWord(input int addr, output logic [7:0] w);
    rdAddr = ADDR_W'(addr);
    #1;
    w = rdData;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=timeout expected=run complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] w;
    logic [3:0] s [4];
    int a, b;
    bit gray, far;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 done", statDone, 0);
    chk("R1 wraddr", statWrAddr, 0);
    chk("R1 id", statId, 8'h5A);
    chk("R1 count", statCount, 4);
    chk("R1 gray", statGray, 0);
    chk("R1 far", statFar, 1);

    // vector table: R3 R4 R5 R7 R8
    for (int v = 0; v < 4; v++) begin
      gray = VEC[v][49];
      far  = VEC[v][48];
      writeCtrl(4, gray, far, 1'b1, 1'b0);
      for (int k = 0; k < 4; k++) begin
        a = int'(VEC[v][47-12*k -: 6]);
        b = int'(VEC[v][41-12*k -: 6]);
        s[k] = sampleOf(a, b, gray);
        runComp(a, b, far);
      end
      waitDone(20);
      chk("R6 vector done", statDone, 1);
      if (!gray && far) begin
        chk("R9 raw wraddr", statWrAddr, 2);
        readWord(0, w);
        chk("R8 R3 R4 R5 raw word0", w, {s[1], s[0]});
        readWord(1, w);
        chk("R8 R3 R4 R5 raw word1", w, {s[3], s[2]});
      end else begin
        chk("R9 corr wraddr", statWrAddr, 1);
        readWord(0, w);
        chk("R7 R3 R4 R5 corrected word",
            w, {xorPair(s[3]), xorPair(s[2]), xorPair(s[1]), xorPair(s[0])});
      end
    end

    // R8 odd raw run: half word flushed with zero padding
    writeCtrl(3, 1'b0, 1'b1, 1'b1, 1'b0);
    runComp(3, 5, 1'b1);
    runComp(4, 1, 1'b1);
    runComp(2, 6, 1'b1);
    waitDone(20);
    chk("R6 odd done", statDone, 1);
    chk("R8 odd wraddr", statWrAddr, 2);
    readWord(0, w);
    chk("R8 odd word0", w, {sampleOf(4, 1, 0), sampleOf(3, 5, 0)});
    readWord(1, w);
    chk("R8 odd padded word1", w, {4'h0, sampleOf(2, 6, 0)});

    // R10 writes during a run are ignored
    writeCtrl(2, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    writeCtrl(7, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R10 count kept", statCount, 2);
    chk("R10 gray kept", statGray, 1);
    chk("R10 far kept", statFar, 0);
    repeat (2 * PERIOD - 8) @(negedge clk);
    chk("R10 R6 done at original length", statDone, 1);
    chk("R9 R7 partial corrected wraddr", statWrAddr, 1);
    readWord(0, w);
    chk("R7 quiet oscillators word", w, 0);
    repeat (40) @(negedge clk);
    chk("R10 done holds", statDone, 1);

    // R6 zero competitions, R10 start clears done
    writeCtrl(0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 start clears done", statDone, 0);
    @(negedge clk);
    chk("R6 zero count done", statDone, 1);
    chk("R9 zero count wraddr", statWrAddr, 0);

    // R2 field load then clear
    writeCtrl(9, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 load count", statCount, 9);
    chk("R2 load gray", statGray, 1);
    chk("R2 load far", statFar, 0);
    chk("R2 load no start", statDone, 1);
    writeCtrl(3, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R2 clear count", statCount, 4);
    chk("R2 clear gray", statGray, 0);
    chk("R2 clear far", statFar, 1);
    repeat (5) @(negedge clk);
    chk("R2 clear does not start", statDone, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule